// File: doc/BRIEF.md
# Indirect-Select Interrupt Controller Front End

This block gathers up to 128 interrupt lines and presents them to a processor as one request line, a vectored acknowledge and a nested end-of-interrupt scheme. Each line has its own configuration: a 3-bit priority, a sense type and a 32-bit vector. Each line also has an enable bit and a pending bit. Software does not reach this state through one address per line. It first writes a 7-bit index into a select register. It then uses a small window of registers that act only on the selected line. The window holds the mode word, the vector word, a mask read, and four one-bit commands: enable, disable, clear and software trigger.

Arbitration looks at every enabled and pending line whose priority is above the level now in service. The highest priority wins, and a tie goes to the lowest index. Reading the vector register acknowledges the winner. The read returns the winner's vector and pushes the line onto an 8-deep stack of lines in service. It also drops the pending bit of an edge-sensed line. Each end-of-interrupt write pops one entry. When no line qualifies, the vector read returns a programmable spurious value. The pending state of all lines can be read as four 32-bit words.

Top module: `irqsel_top`

## Requirements
- R1: The select register at 0x00 stores bits 6:0 of the written word, and reads return them in bits 6:0 with the upper bits zero. Its reset value is 0.
- R2: The mode register (0x04) and the vector register (0x08) read and write the configuration of the selected line only. In the mode word, the priority is bits 2:0 and the sense type is bits 6:5. Mode bits 7 and 4:3 read as zero. The mode resets to 0x40 (level high, priority 0) and the vector resets to 0.
- R3: When the select value is at or above NUM_SRC, writes to the mode and vector registers and to the four command registers change nothing. Reads of the mode, vector and mask registers then return zero.
- R4: Writing a word with bit 0 set acts on the selected line. At 0x40 it enables the line, at 0x44 it disables it, at 0x48 it clears an edge-sensed line's pending bit, and at 0x4C it sets that bit. The mask register at 0x30 returns the selected line's enable bit in bit 0. A disabled line never drives the request output.
- R5: The sense codes are 00 level low, 01 falling edge, 10 level high and 11 rising edge. A level-sensed line's pending bit follows its active level one clock later, and the clear and set commands do not affect it. An edge-sensed line latches its pending bit on the matching edge.
- R6: The pending words at 0x20, 0x24, 0x28 and 0x2C hold line n at bit n mod 32 of word n/32. Bits for lines at or above NUM_SRC read as zero.
- R7: irq_out is high exactly when some enabled, pending line has a priority strictly above the top of the in-service stack, or when such a line exists and the stack is empty. The winner is the line with the highest priority, and a tie goes to the lowest index.
- R8: A read of 0x10 returns the winner's vector, pushes the winner onto the in-service stack and clears the winner's pending bit if its sense is edge. With no winner, the read returns the spurious word, which is read and written at 0x3C, and changes nothing.
- R9: The status register at 0x18 returns the index of the line on top of the stack in bits 6:0, with bit 31 set. It returns 0 when the stack is empty.
- R10: A write to 0x38 pops one stack entry. A pop of an empty stack has no effect.
- R11: A select write followed in the very next cycle by a windowed write acts on the newly selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Raw interrupt lines |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The stack checks assume that the processor makes at most one register access per cycle. Under that assumption an acknowledge and an end-of-interrupt never fall in the same cycle. The checks also assume that every acknowledge is eventually matched by one end-of-interrupt write. The stimulus drives the bus through single-access tasks that hold bus_en for exactly one clock. It pairs every vector read that has a winner with a later end-of-interrupt write. It changes the source lines only at falling clock edges, so each edge is seen by exactly one sampling edge.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int IDX_W  = 7;
  localparam int PRIO_W = 3;
  localparam int DATA_W = 32;

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_FALL = 2'b01;
  localparam logic [1:0] SENSE_HIGH = 2'b10;
  localparam logic [1:0] SENSE_RISE = 2'b11;

  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_VEC  = 8'h08;
  localparam logic [7:0] OFF_IVR  = 8'h10;
  localparam logic [7:0] OFF_STAT = 8'h18;
  localparam logic [7:0] OFF_PND0 = 8'h20;
  localparam logic [7:0] OFF_PND1 = 8'h24;
  localparam logic [7:0] OFF_PND2 = 8'h28;
  localparam logic [7:0] OFF_PND3 = 8'h2C;
  localparam logic [7:0] OFF_MASK = 8'h30;
  localparam logic [7:0] OFF_EOI  = 8'h38;
  localparam logic [7:0] OFF_SPUR = 8'h3C;
  localparam logic [7:0] OFF_ENA  = 8'h40;
  localparam logic [7:0] OFF_DIS  = 8'h44;
  localparam logic [7:0] OFF_CLR  = 8'h48;
  localparam logic [7:0] OFF_SET  = 8'h4C;

  // bit 0 of the sense code selects edge sensing
  function automatic logic sense_is_edge(input logic [1:0] s);
    return s[0];
  endfunction

  // bit 1 selects the active polarity
  function automatic logic level_on(input logic [1:0] s, input logic x);
    return s[1] ? x : ~x;
  endfunction

  function automatic logic edge_on(input logic [1:0] s, input logic x, input logic prev);
    return s[1] ? (x & ~prev) : (~x & prev);
  endfunction

  function automatic logic [7:0] pack_mode(input logic [1:0] s, input logic [PRIO_W-1:0] p);
    return {1'b0, s, 2'b00, p};
  endfunction
endpackage

// File: rtl/irqsel_src_bank.sv
module irqsel_src_bank
  import irqsel_pkg::*;
#(
  parameter int NUM_SRC = 50
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_in,
  input  logic [IDX_W-1:0]                sel,
  input  logic                            wr_mode,
  input  logic [PRIO_W-1:0]               new_prio,
  input  logic [1:0]                      new_sense,
  input  logic                            wr_vec,
  input  logic [DATA_W-1:0]               new_vec,
  input  logic                            cmd_en,
  input  logic                            cmd_dis,
  input  logic                            cmd_clr,
  input  logic                            cmd_set,
  input  logic                            ack,
  input  logic [IDX_W-1:0]                ack_idx,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0]              pend_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC-1:0][1:0]         sense_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0]  vec_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic              hit, acked, edge_ev;
    logic              prev_q, en_q, pend_q;
    logic [PRIO_W-1:0] prio_q;
    logic [1:0]        sense_q;
    logic [DATA_W-1:0] vec_q;

    assign hit     = (sel == IDX_W'(i));
    assign acked   = ack && (ack_idx == IDX_W'(i));
    assign edge_ev = edge_on(sense_q, src_in[i], prev_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        en_q    <= 1'b0;
        pend_q  <= 1'b0;
        prio_q  <= '0;
        sense_q <= SENSE_HIGH;
        vec_q   <= '0;
      end else begin
        prev_q <= src_in[i];
        if (wr_mode && hit) begin
          prio_q  <= new_prio;
          sense_q <= new_sense;
        end
        if (wr_vec && hit) vec_q <= new_vec;
        if (cmd_en && hit)       en_q <= 1'b1;
        else if (cmd_dis && hit) en_q <= 1'b0;
        if (!sense_is_edge(sense_q))
          pend_q <= level_on(sense_q, src_in[i]);
        else
          pend_q <= (pend_q & ~(cmd_clr & hit) & ~acked) | edge_ev | (cmd_set & hit);
      end
    end

    assign en_o[i]    = en_q;
    assign pend_o[i]  = pend_q;
    assign prio_o[i]  = prio_q;
    assign sense_o[i] = sense_q;
    assign vec_o[i]   = vec_q;
  end
endmodule

// File: rtl/irqsel_arbiter.sv
module irqsel_arbiter
  import irqsel_pkg::*;
#(
  parameter int NUM_SRC = 50
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic                           cur_valid,
  input  logic [PRIO_W-1:0]              cur_prio,
  output logic                           win_valid,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);
  // strict compare keeps the lowest index on equal priority
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && en[i] && (!cur_valid || prio[i] > cur_prio) &&
          (!win_valid || prio[i] > win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqsel_stack.sv
module irqsel_stack
  import irqsel_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic              top_valid,
  output logic [IDX_W-1:0]  top_idx,
  output logic [PRIO_W-1:0] top_prio
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  wptr, tptr;

  assign wptr      = PTR_W'(cnt_q);
  assign tptr      = PTR_W'(cnt_q - 1'b1);
  assign top_valid = (cnt_q != '0);
  assign top_idx   = top_valid ? idx_q[tptr]  : '0;
  assign top_prio  = top_valid ? prio_q[tptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        idx_q[k]  <= '0;
        prio_q[k] <= '0;
      end
    end else if (push && (int'(cnt_q) < DEPTH)) begin
      idx_q[wptr]  <= push_idx;
      prio_q[wptr] <= push_prio;
      cnt_q        <= cnt_q + 1'b1;
    end else if (pop && top_valid) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(cnt_q) < DEPTH));
  // R8
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R10
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && top_valid) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
#(
  parameter int NUM_SRC   = 50,
  parameter int NEST_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int PEND_BITS = 128;

  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] spur_q;
  logic              wr, rd, sel_ok, win_wr, bit0;
  logic              wr_mode, wr_vec, cmd_en, cmd_dis, cmd_clr, cmd_set;
  logic              ack, pop;

  logic [NUM_SRC-1:0]              en_vec, pend_vec;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_arr;
  logic [NUM_SRC-1:0][1:0]         sense_arr;
  logic [NUM_SRC-1:0][DATA_W-1:0]  vec_arr;
  logic [PEND_BITS-1:0]            pend_pad;

  logic              win_valid, top_valid;
  logic [IDX_W-1:0]  win_idx, top_idx;
  logic [PRIO_W-1:0] win_prio, top_prio;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign sel_ok  = (int'(sel_q) < NUM_SRC);
  assign win_wr  = wr && sel_ok;
  assign bit0    = bus_wdata[0];
  assign wr_mode = win_wr && (bus_addr == OFF_MODE);
  assign wr_vec  = win_wr && (bus_addr == OFF_VEC);
  assign cmd_en  = win_wr && bit0 && (bus_addr == OFF_ENA);
  assign cmd_dis = win_wr && bit0 && (bus_addr == OFF_DIS);
  assign cmd_clr = win_wr && bit0 && (bus_addr == OFF_CLR);
  assign cmd_set = win_wr && bit0 && (bus_addr == OFF_SET);
  assign ack     = rd && (bus_addr == OFF_IVR) && win_valid;
  assign pop     = wr && (bus_addr == OFF_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      spur_q <= '0;
    end else if (wr) begin
      if (bus_addr == OFF_SEL)  sel_q  <= bus_wdata[IDX_W-1:0];
      if (bus_addr == OFF_SPUR) spur_q <= bus_wdata;
    end
  end

  irqsel_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sel(sel_q),
    .wr_mode(wr_mode), .new_prio(bus_wdata[PRIO_W-1:0]), .new_sense(bus_wdata[6:5]),
    .wr_vec(wr_vec), .new_vec(bus_wdata),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_clr(cmd_clr), .cmd_set(cmd_set),
    .ack(ack), .ack_idx(win_idx),
    .en_o(en_vec), .pend_o(pend_vec), .prio_o(prio_arr), .sense_o(sense_arr), .vec_o(vec_arr)
  );

  irqsel_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend(pend_vec), .en(en_vec), .prio(prio_arr),
    .cur_valid(top_valid), .cur_prio(top_prio),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  irqsel_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack), .push_idx(win_idx), .push_prio(win_prio),
    .pop(pop), .top_valid(top_valid), .top_idx(top_idx), .top_prio(top_prio)
  );

  assign irq_out  = win_valid;
  assign pend_pad = PEND_BITS'(pend_vec);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_SEL:  bus_rdata = DATA_W'(sel_q);
      OFF_MODE: bus_rdata = sel_ok ? DATA_W'(pack_mode(sense_arr[sel_q], prio_arr[sel_q])) : '0;
      OFF_VEC:  bus_rdata = sel_ok ? vec_arr[sel_q] : '0;
      OFF_IVR:  bus_rdata = win_valid ? vec_arr[win_idx] : spur_q;
      OFF_STAT: bus_rdata = top_valid ? {1'b1, 24'b0, top_idx} : '0;
      OFF_PND0: bus_rdata = pend_pad[31:0];
      OFF_PND1: bus_rdata = pend_pad[63:32];
      OFF_PND2: bus_rdata = pend_pad[95:64];
      OFF_PND3: bus_rdata = pend_pad[127:96];
      OFF_MASK: bus_rdata = sel_ok ? DATA_W'(en_vec[sel_q]) : '0;
      OFF_SPUR: bus_rdata = spur_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R7
  irq_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((pend_vec & en_vec) != '0));
  // R3
  oob_cmd_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel_ok && (bus_addr == OFF_ENA || bus_addr == OFF_DIS)) |=> $stable(en_vec));
endmodule

// File: tb/irqsel_top_tb.sv
module irqsel_top_tb;
  localparam int N = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;
  int            total = 0, bad = 0;
  logic [31:0]   d;

  always #4 clk = ~clk;

  irqsel_top #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {index[6:0], mode[7:0], vector[31:0]}
  localparam logic [46:0] CFG_TAB [6] = '{
    {7'd3,  8'h62, 32'h1000_0003},
    {7'd7,  8'h62, 32'h1000_0007},
    {7'd9,  8'h65, 32'h1000_0009},
    {7'd12, 8'h41, 32'h1000_000C},
    {7'd40, 8'h24, 32'h1000_0028},
    {7'd49, 8'h66, 32'h1000_0031}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    chk("R7 reset irq", 32'(irq_out), 32'd0);
    rd(8'h00, d); chk("R1 reset select", d, 32'd0);
    rd(8'h04, d); chk("R2 reset mode", d, 32'h40);
    rd(8'h20, d); chk("R6 reset pending", d, 32'd0);
    rd(8'h18, d); chk("R9 reset status", d, 32'd0);

    // table walk: configure and read back (R2)
    for (int k = 0; k < 6; k++) begin
      wr(8'h00, 32'(CFG_TAB[k][46:40]));
      wr(8'h04, 32'(CFG_TAB[k][39:32]));
      wr(8'h08, CFG_TAB[k][31:0]);
      rd(8'h04, d); chk("R2 mode readback", d, 32'(CFG_TAB[k][39:32]));
      rd(8'h08, d); chk("R2 vector readback", d, CFG_TAB[k][31:0]);
    end

    // R1 select width
    wr(8'h00, 32'h2A);   rd(8'h00, d); chk("R1 select", d, 32'h2A);
    wr(8'h00, 32'hFFFF); rd(8'h00, d); chk("R1 select trunc", d, 32'h7F);

    // R3 out-of-range window
    wr(8'h00, 32'd100);
    wr(8'h04, 32'h66); wr(8'h08, 32'h1234);
    wr(8'h40, 32'd1);  wr(8'h4C, 32'd1);
    rd(8'h04, d); chk("R3 mode read zero", d, 32'd0);
    rd(8'h08, d); chk("R3 vector read zero", d, 32'd0);
    rd(8'h30, d); chk("R3 mask read zero", d, 32'd0);
    rd(8'h24, d); chk("R3 no pending set", d, 32'd0);
    rd(8'h28, d); chk("R3 word2 zero", d, 32'd0);

    // R11 select then command back to back, R4 enables
    wr(8'h00, 32'd3);  wr(8'h40, 32'd1);
    rd(8'h30, d); chk("R11 enable hit new select", d, 32'd1);
    wr(8'h00, 32'd7);  wr(8'h40, 32'd1);
    wr(8'h00, 32'd9);  wr(8'h40, 32'd1);
    wr(8'h00, 32'd12); wr(8'h40, 32'd1);
    wr(8'h00, 32'd40); wr(8'h40, 32'd1);
    wr(8'h00, 32'd49); wr(8'h40, 32'd1);
    wr(8'h44, 32'd1);
    rd(8'h30, d); chk("R4 disable mask", d, 32'd0);
    wr(8'h40, 32'd0);
    rd(8'h30, d); chk("R4 bit0 clear ignored", d, 32'd0);

    // R5 rising edge, R8 acknowledge
    tick; src_in[3] = 1'b1; tick;
    rd(8'h20, d); chk("R5 rising latched", d, 32'h8);
    chk("R7 irq on pending", 32'(irq_out), 32'd1);
    rd(8'h10, d); chk("R8 vector of winner", d, 32'h1000_0003);
    rd(8'h20, d); chk("R8 edge pending cleared", d, 32'd0);
    rd(8'h18, d); chk("R9 in-service index", d, 32'h8000_0003);
    chk("R7 irq drops in service", 32'(irq_out), 32'd0);
    tick; src_in[7] = 1'b1; tick;
    chk("R7 equal prio not nested", 32'(irq_out), 32'd0);
    tick; src_in[9] = 1'b1; tick;
    chk("R7 higher prio nests", 32'(irq_out), 32'd1);
    rd(8'h10, d); chk("R8 nested vector", d, 32'h1000_0009);
    wr(8'h38, 32'd0);
    rd(8'h18, d); chk("R10 pop to outer", d, 32'h8000_0003);
    wr(8'h38, 32'd0);
    chk("R7 waiting source rises", 32'(irq_out), 32'd1);
    rd(8'h10, d); chk("R8 waiting vector", d, 32'h1000_0007);
    wr(8'h38, 32'd0); wr(8'h38, 32'd0);
    rd(8'h18, d); chk("R10 empty pop inert", d, 32'd0);

    // R7 tie: lowest index wins; R4 software set
    wr(8'h00, 32'd7); wr(8'h4C, 32'd1);
    wr(8'h00, 32'd3); wr(8'h4C, 32'd1);
    rd(8'h20, d); chk("R4 set pending", d, 32'h88);
    rd(8'h10, d); chk("R7 tie lowest index", d, 32'h1000_0003);
    wr(8'h38, 32'd0);
    rd(8'h10, d); chk("R7 tie second", d, 32'h1000_0007);
    wr(8'h38, 32'd0);

    // R4 clear
    wr(8'h00, 32'd3); wr(8'h4C, 32'd1); wr(8'h48, 32'd1);
    rd(8'h20, d); chk("R4 clear pending", d, 32'd0);

    // R5 level high source 12
    tick; src_in[12] = 1'b1; tick;
    rd(8'h20, d); chk("R5 level pending", d, 32'h1000);
    chk("R7 level irq", 32'(irq_out), 32'd1);
    wr(8'h00, 32'd12); wr(8'h48, 32'd1);
    rd(8'h20, d); chk("R5 clear ignored on level", d, 32'h1000);
    tick; src_in[12] = 1'b0; tick;
    rd(8'h20, d); chk("R5 level follows line", d, 32'd0);
    chk("R7 level irq gone", 32'(irq_out), 32'd0);

    // R5 falling edge on 40, R6 word1
    tick; src_in[40] = 1'b1; tick;
    rd(8'h24, d); chk("R5 falling not on rise", d, 32'd0);
    tick; src_in[40] = 1'b0; tick;
    rd(8'h24, d); chk("R6 word1 bit8", d, 32'h100);
    rd(8'h10, d); chk("R8 falling vector", d, 32'h1000_0028);
    wr(8'h38, 32'd0);

    // R4 disabled source never requests, R6 upper word
    wr(8'h00, 32'd49); wr(8'h4C, 32'd1);
    rd(8'h24, d); chk("R6 word1 bit17", d, 32'h2_0000);
    chk("R4 disabled no irq", 32'(irq_out), 32'd0);
    rd(8'h2C, d); chk("R6 word3 zero", d, 32'd0);
    wr(8'h48, 32'd1);

    // R8 spurious
    wr(8'h3C, 32'hDEAD_BEEF);
    rd(8'h3C, d); chk("R8 spurious readback", d, 32'hDEAD_BEEF);
    rd(8'h10, d); chk("R8 spurious on idle", d, 32'hDEAD_BEEF);
    rd(8'h18, d); chk("R8 spurious no push", d, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule